// File: doc/BRIEF.md
# Processor bus command controller

This block turns the three-bit bus status code that a processor presents at the start of each bus cycle into the command strobes and transceiver controls of the external buses. It drives active-low strobes for memory read, memory write, I/O read, I/O write and interrupt acknowledge. Each write also has an early form that fires with read timing, which lets slow memories and peripherals start a write sooner. It also drives a data enable, a transmit/receive direction line and one shared enable pin.

A static strap chooses between two bus arrangements. With the strap low, there is a single shared bus. Every command then waits until the arbitration grant input (active low) has been seen low on `DELAY` consecutive clock edges. With the strap high, I/O and interrupt-acknowledge commands go to a private I/O bus and fire at once, while memory commands still wait for the grant. The shared pin follows the strap. With the strap low it is an active-high cascade enable during interrupt acknowledge. With the strap high it is an active-low enable for the I/O-bus transceiver.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: The status code is decoded as follows. 000 gives interrupt acknowledge. 001 gives I/O read. 010 gives I/O write, with both the early and the normal I/O write strobes. 100 and 101 give memory read. 110 gives memory write, with both the early and the normal memory write strobes. At most one of the read-timed strobes (memory read, early memory write, I/O read, early I/O write, interrupt acknowledge) is low at any time.
- R2: With the strap high, a cycle with code 000, 001 or 010 asserts its read-timed strobe one clock after the cycle starts, whatever the level of the grant input.
- R3: With the strap high, memory cycles (codes 100, 101, 110) issue no strobe until the grant has been sampled low on `DELAY` consecutive edges, counting from the edge that starts the cycle.
- R4: With the strap low, every command waits as described in R3. If the grant is sampled high during the wait, the count starts again from zero.
- R5: The normal write strobe goes low exactly one clock after its early strobe and goes high on the same edge.
- R6: A cycle starts on the first edge at which a command code (anything but 011 or 111) is sampled. All strobes and enables go inactive on the first edge at which 111 or 011 is sampled.
- R7: While the code stays at 011 (halt) or 111 (passive), every strobe stays high, data enable stays low, and the shared pin stays inactive.
- R8: Data enable is high exactly while a command strobe is active. With the strap high, this applies only to memory commands.
- R9: The direction output is high from the start to the end of a write cycle (code 010 or 110). At all other times it is low.
- R10: With the strap low, the shared pin is high exactly while interrupt acknowledge is active. With the strap high, it is low exactly while an I/O read, I/O write or interrupt acknowledge is active.
- R11: During reset, all strobes are high, data enable and direction are low, and the shared pin is inactive for the strap level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | 3 | Bus status code from the processor |
| io_strap_i | input | 1 | Mode strap: 1 = private I/O bus, 0 = single shared bus |
| grant_ni | input | 1 | Bus grant from the arbiter, active low |
| mem_rd_no | output | 1 | Memory read strobe, active low |
| mem_wr_no | output | 1 | Memory write strobe, active low |
| mem_wr_early_no | output | 1 | Early memory write strobe, active low |
| io_rd_no | output | 1 | I/O read strobe, active low |
| io_wr_no | output | 1 | I/O write strobe, active low |
| io_wr_early_no | output | 1 | Early I/O write strobe, active low |
| int_ack_no | output | 1 | Interrupt acknowledge strobe, active low |
| data_en_o | output | 1 | Data transceiver enable, active high |
| xmit_o | output | 1 | Transceiver direction: 1 = transmit, 0 = receive |
| casc_pen_o | output | 1 | Cascade enable (strap low, active high) or I/O transceiver enable (strap high, active low) |

## Verification
The hardest case to reach is a grant wait that restarts. It needs a gated cycle held open while the grant is low for fewer than `DELAY` edges, then released, then lowered again. The bench holds a memory-read code with the grant high, drops the grant for a single clock, raises it again, and only then holds it low. It checks that the strobe appears exactly `DELAY` edges after the final drop and not earlier. The bench also steps through all eight codes under both strap levels, and checks every output on every clock of each cycle against a model built from the requirements.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_CMD  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e      phase;
        logic [2:0]  code;
        logic        late;
    } ctl_s;

    // Codes 011 (halt) and 111 (passive) issue nothing.
    function automatic logic is_cmd_code(input logic [2:0] c);
        return (c != 3'b111) && (c != 3'b011);
    endfunction

    function automatic logic is_mem_code(input logic [2:0] c);
        return c[2] && (c != 3'b111);
    endfunction

    function automatic logic is_write_code(input logic [2:0] c);
        return (c == 3'b010) || (c == 3'b110);
    endfunction

endpackage

// File: rtl/bcc_grant_timer.sv
module bcc_grant_timer #(
    parameter int DELAY = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic count_en_i,
    input  logic grant_ni,
    output logic ready_o
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        ready_o = !grant_ni && ((int'(cnt_q) + 1) >= DELAY);
        cnt_d   = '0;
        if (count_en_i && !grant_ni && !ready_o) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/bcc_strobe_decode.sv
module bcc_strobe_decode (
    input  logic       active_i,
    input  logic       late_i,
    input  logic       in_cycle_i,
    input  logic [2:0] code_i,
    input  logic       io_strap_i,
    output logic       mem_rd_no,
    output logic       mem_wr_no,
    output logic       mem_wr_early_no,
    output logic       io_rd_no,
    output logic       io_wr_no,
    output logic       io_wr_early_no,
    output logic       int_ack_no,
    output logic       data_en_o,
    output logic       xmit_o,
    output logic       casc_pen_o
);
    import bcc_pkg::*;

    logic mrd, mwe, mw, iord, iowe, iow, inta, io_act, mem_act;

    always_comb begin
        mrd  = active_i && ((code_i == 3'b100) || (code_i == 3'b101));
        mwe  = active_i && (code_i == 3'b110);
        mw   = mwe && late_i;
        iord = active_i && (code_i == 3'b001);
        iowe = active_i && (code_i == 3'b010);
        iow  = iowe && late_i;
        inta = active_i && (code_i == 3'b000);

        io_act  = iord || iowe || inta;
        mem_act = mrd || mwe;

        mem_rd_no       = !mrd;
        mem_wr_no       = !mw;
        mem_wr_early_no = !mwe;
        io_rd_no        = !iord;
        io_wr_no        = !iow;
        io_wr_early_no  = !iowe;
        int_ack_no      = !inta;

        data_en_o  = io_strap_i ? mem_act : (mem_act || io_act);
        xmit_o     = in_cycle_i && is_write_code(code_i);
        casc_pen_o = io_strap_i ? !io_act : inta;
    end

endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl #(
    parameter int DELAY = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] status_i,
    input  logic       io_strap_i,
    input  logic       grant_ni,
    output logic       mem_rd_no,
    output logic       mem_wr_no,
    output logic       mem_wr_early_no,
    output logic       io_rd_no,
    output logic       io_wr_no,
    output logic       io_wr_early_no,
    output logic       int_ack_no,
    output logic       data_en_o,
    output logic       xmit_o,
    output logic       casc_pen_o
);
    import bcc_pkg::*;

    ctl_s st_d, st_q;
    logic timer_en, grant_ready, gated_new, gated_cur;

    bcc_grant_timer #(.DELAY(DELAY)) timer_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .count_en_i (timer_en),
        .grant_ni   (grant_ni),
        .ready_o    (grant_ready)
    );

    always_comb begin
        st_d      = st_q;
        timer_en  = 1'b0;
        gated_new = !io_strap_i || is_mem_code(status_i);
        gated_cur = !io_strap_i || is_mem_code(st_q.code);
        unique case (st_q.phase)
            PH_IDLE: begin
                st_d.late = 1'b0;
                if (is_cmd_code(status_i)) begin
                    st_d.code = status_i;
                    if (!gated_new || grant_ready) begin
                        st_d.phase = PH_CMD;
                    end else begin
                        st_d.phase = PH_WAIT;
                        timer_en   = 1'b1;
                    end
                end
            end
            PH_WAIT: begin
                if (!is_cmd_code(status_i)) begin
                    st_d.phase = PH_IDLE;
                end else if (!gated_cur || grant_ready) begin
                    st_d.phase = PH_CMD;
                end else begin
                    timer_en = 1'b1;
                end
            end
            PH_CMD: begin
                if (!is_cmd_code(status_i)) begin
                    st_d.phase = PH_IDLE;
                    st_d.late  = 1'b0;
                end else begin
                    st_d.late = 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.late  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, code: 3'b111, late: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    bcc_strobe_decode dec_i (
        .active_i        (st_q.phase == PH_CMD),
        .late_i          (st_q.late),
        .in_cycle_i      (st_q.phase != PH_IDLE),
        .code_i          (st_q.code),
        .io_strap_i      (io_strap_i),
        .mem_rd_no       (mem_rd_no),
        .mem_wr_no       (mem_wr_no),
        .mem_wr_early_no (mem_wr_early_no),
        .io_rd_no        (io_rd_no),
        .io_wr_no        (io_wr_no),
        .io_wr_early_no  (io_wr_early_no),
        .int_ack_no      (int_ack_no),
        .data_en_o       (data_en_o),
        .xmit_o          (xmit_o),
        .casc_pen_o      (casc_pen_o)
    );

endmodule

// File: rtl/bus_cmd_ctrl_chk.sv
module bus_cmd_ctrl_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [2:0] status_i,
    input logic       io_strap_i,
    input logic       grant_ni,
    input logic       mem_rd_no,
    input logic       mem_wr_no,
    input logic       mem_wr_early_no,
    input logic       io_rd_no,
    input logic       io_wr_no,
    input logic       io_wr_early_no,
    input logic       int_ack_no,
    input logic       data_en_o,
    input logic       xmit_o,
    input logic       casc_pen_o
);
    logic any_cmd, io_cmd;
    assign any_cmd = !(mem_rd_no && mem_wr_early_no && io_rd_no && io_wr_early_no && int_ack_no);
    assign io_cmd  = !io_rd_no || !io_wr_early_no || !int_ack_no;

    a_r1_single_command: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({!mem_rd_no, !mem_wr_early_no, !io_rd_no, !io_wr_early_no, !int_ack_no}) <= 1);

    a_r5_mem_late_inside_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem_wr_no |-> !mem_wr_early_no);

    a_r5_io_late_inside_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !io_wr_no |-> !io_wr_early_no);

    a_r5_mem_late_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mem_wr_no) |-> $past(!mem_wr_early_no));

    a_r6_release_on_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_i == 3'b111) |=> (mem_rd_no && mem_wr_no && mem_wr_early_no && io_rd_no
                                  && io_wr_no && io_wr_early_no && int_ack_no));

    a_r4_mem_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!io_strap_i && $fell(mem_rd_no)) |-> $past(!grant_ni));

    a_r4_io_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!io_strap_i && $fell(io_rd_no)) |-> $past(!grant_ni));

    a_r8_den_with_command: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_en_o |-> any_cmd);

    a_r9_write_transmits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mem_wr_early_no || !io_wr_early_no) |-> xmit_o);

    a_r10_io_enable_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (io_strap_i && io_cmd) |-> !casc_pen_o);

endmodule

bind bus_cmd_ctrl bus_cmd_ctrl_chk chk_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .status_i        (status_i),
    .io_strap_i      (io_strap_i),
    .grant_ni        (grant_ni),
    .mem_rd_no       (mem_rd_no),
    .mem_wr_no       (mem_wr_no),
    .mem_wr_early_no (mem_wr_early_no),
    .io_rd_no        (io_rd_no),
    .io_wr_no        (io_wr_no),
    .io_wr_early_no  (io_wr_early_no),
    .int_ack_no      (int_ack_no),
    .data_en_o       (data_en_o),
    .xmit_o          (xmit_o),
    .casc_pen_o      (casc_pen_o)
);

// File: tb/bus_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_cmd_ctrl_tb_top;
    localparam int DELAY = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] status = 3'b111;
    logic strap = 1'b0;
    logic grant_n = 1'b1;
    logic mem_rd_n, mem_wr_n, mem_wre_n, io_rd_n, io_wr_n, io_wre_n, inta_n;
    logic den, xmit, casc;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_cmd_ctrl #(.DELAY(DELAY)) dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .status_i        (status),
        .io_strap_i      (strap),
        .grant_ni        (grant_n),
        .mem_rd_no       (mem_rd_n),
        .mem_wr_no       (mem_wr_n),
        .mem_wr_early_no (mem_wre_n),
        .io_rd_no        (io_rd_n),
        .io_wr_no        (io_wr_n),
        .io_wr_early_no  (io_wre_n),
        .int_ack_no      (inta_n),
        .data_en_o       (den),
        .xmit_o          (xmit),
        .casc_pen_o      (casc)
    );

    wire [9:0] obs = {mem_rd_n, mem_wr_n, mem_wre_n, io_rd_n, io_wr_n, io_wre_n,
                      inta_n, den, xmit, casc};

    // Model from the requirements: rd_on = read-timed strobes due, wr_on = normal writes due.
    function automatic logic [9:0] model(input logic [2:0] c, input logic s,
                                         input logic rd_on, input logic wr_on, input logic in_cyc);
        logic mrd, mwe, mw, ird, iwe, iw, ia, ioa, mema;
        mrd  = rd_on && (c == 3'b100 || c == 3'b101);
        mwe  = rd_on && (c == 3'b110);
        mw   = wr_on && (c == 3'b110);
        ird  = rd_on && (c == 3'b001);
        iwe  = rd_on && (c == 3'b010);
        iw   = wr_on && (c == 3'b010);
        ia   = rd_on && (c == 3'b000);
        ioa  = ird || iwe || ia;
        mema = mrd || mwe;
        return {!mrd, !mw, !mwe, !ird, !iw, !iwe, !ia,
                s ? mema : (mema || ioa),
                in_cyc && (c == 3'b010 || c == 3'b110),
                s ? !ioa : ia};
    endfunction

    task automatic check(input string req, input logic [9:0] exp);
        n_cmp++;
        if (obs !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, obs, exp);
        end
    endtask

    task automatic reset_test();
        @(negedge clk);
        check("R11", model(3'b111, 1'b0, 1'b0, 1'b0, 1'b0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", model(3'b111, 1'b0, 1'b0, 1'b0, 1'b0));
    endtask

    // One full cycle of a given code, grant held low, checked every clock.
    task automatic code_cycle(input logic [2:0] c, input logic s);
        int act;
        logic cmd;
        string lbl;
        cmd = (c != 3'b111) && (c != 3'b011);
        act = (!s || c[2]) ? DELAY : 1;
        lbl = !cmd ? "R7" : (s ? "R1 R2 R3 R5 R8 R9 R10" : "R1 R4 R5 R8 R9 R10");
        strap   = s;
        grant_n = 1'b0;
        status  = c;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check(lbl, model(c, s, cmd && k >= act, cmd && k >= act + 1, cmd));
        end
        status = 3'b111;
        @(negedge clk);
        check("R6", model(c, s, 1'b0, 1'b0, 1'b0));
        @(negedge clk);
        check("R6 R7", model(3'b111, s, 1'b0, 1'b0, 1'b0));
    endtask

    // Strap low: grant pulse too short, then restart of the count.
    task automatic restart_test();
        strap   = 1'b0;
        grant_n = 1'b1;
        status  = 3'b101;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R4 no grant", model(3'b101, 1'b0, 1'b0, 1'b0, 1'b1));
        end
        grant_n = 1'b0;
        @(negedge clk);
        check("R4 one low edge", model(3'b101, 1'b0, 1'b0, 1'b0, 1'b1));
        grant_n = 1'b1;
        @(negedge clk);
        check("R4 restart", model(3'b101, 1'b0, 1'b0, 1'b0, 1'b1));
        grant_n = 1'b0;
        @(negedge clk);
        check("R4 count again", model(3'b101, 1'b0, 1'b0, 1'b0, 1'b1));
        @(negedge clk);
        check("R4 granted", model(3'b101, 1'b0, 1'b1, 1'b0, 1'b1));
        status = 3'b111;
        @(negedge clk);
        check("R6", model(3'b111, 1'b0, 1'b0, 1'b0, 1'b0));
    endtask

    // Strap high, grant withheld: I/O runs, memory waits.
    task automatic strap_high_nogrant();
        strap   = 1'b1;
        grant_n = 1'b1;
        status  = 3'b001;
        @(negedge clk);
        check("R2 io read without grant", model(3'b001, 1'b1, 1'b1, 1'b0, 1'b1));
        status = 3'b111;
        @(negedge clk);
        check("R6", model(3'b111, 1'b1, 1'b0, 1'b0, 1'b0));
        status = 3'b110;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R3 mem write waits", model(3'b110, 1'b1, 1'b0, 1'b0, 1'b1));
        end
        grant_n = 1'b0;
        @(negedge clk);
        check("R3 first grant edge", model(3'b110, 1'b1, 1'b0, 1'b0, 1'b1));
        @(negedge clk);
        check("R3 R5 early write", model(3'b110, 1'b1, 1'b1, 1'b0, 1'b1));
        @(negedge clk);
        check("R5 normal write", model(3'b110, 1'b1, 1'b1, 1'b1, 1'b1));
        status = 3'b111;
        @(negedge clk);
        check("R5 R6 joint release", model(3'b111, 1'b1, 1'b0, 1'b0, 1'b0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        reset_test();
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 8; c++) begin
                code_cycle(3'(c), 1'(s));
            end
        end
        restart_test();
        strap_high_nogrant();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule